// File: doc/BRIEF.md
# Multi-Channel SPI Register Access Engine

This block is the host side of a serial link to a chain of telephony line-interface channels that share one SPI bus. A client hands it one request at a time: a channel number, a register address, a read or write direction, a data byte and a broadcast flag. The engine forms a command byte from these fields. It shifts the command, the register address and a third byte over the bus. On a write the third byte is the data. On a read the third byte is returned by the addressed channel.

Inside the command byte the channel field is carried with its five bits in reversed order. A broadcast write reaches every channel and ignores the channel bits. A request naming a channel the configuration does not provide is refused at once, and the bus is not touched.

Each byte travels in its own chip-select frame. The bus clock is a divided copy of the system clock, idles high and is sampled by the receiver on its rising edge.

Top module: `spi_chan_master`

## Requirements
- R1: The command byte is 0x60 OR the encoded channel for a read and 0x20 OR the encoded channel for a write; the encoded channel occupies bits 4..0.
- R2: The encoded channel is the 5-bit channel number with bit i moved to bit 4-i (channel 1 gives 0x10, channel 2 gives 0x08, channel 3 gives 0x18).
- R3: A write with `req_bcast` high, or with `req_chan` equal to 0xFF, sends command byte 0xA0 whatever the channel bits are.
- R4: A read with broadcast selected, or any non-broadcast request with `req_chan` at or above CHAN_MAX, raises `err` together with `done` in the cycle after acceptance, and `cs_n` stays high for that request.
- R5: A write sends exactly three frames, in this order: command, register address, data.
- R6: A read sends the command and the register address, then runs a third frame that clocks in one byte from `miso`, MSB first. That byte appears on `rd_data` with `done`.
- R7: The bus uses SPI mode 3. `sclk` is high whenever `cs_n` is high. `mosi` changes only on a falling `sclk` edge. Bytes are sent MSB first.
- R8: Each byte has its own `cs_n` low frame with exactly eight rising `sclk` edges. Between frames `cs_n` stays high for at least one `sclk` period (2*HALF_DIV system clocks).
- R9: `req_ready` is high only while the engine is idle, and a request is taken only when `req_valid` and `req_ready` are both high. `done` is a single-cycle pulse. `rd_data` holds its value until the next read completes.
- R10: After reset `cs_n` and `sclk` are high, `req_ready` is high, and `done` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to accept a request |
| req_chan | input | 8 | Channel number (0xFF selects broadcast) |
| req_addr | input | 8 | Register address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bcast | input | 1 | Broadcast flag |
| req_wdata | input | 8 | Write data |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Request refused (valid with done) |
| rd_data | output | 8 | Byte returned by the last read |
| sclk | output | 1 | Bus clock, idles high |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the channels |
| miso | input | 1 | Serial data from the channels |

## Verification
The bench builds the engine with CHAN_MAX=8, HALF_DIV=2 and GAP_TICKS=2. With these values every legal channel can be swept as both a read and a write, and the first illegal channel and the far edge of the 5-bit field are both reached. The bench also covers broadcast through the flag and through the 0xFF channel value, plus a broadcast read. With the short divider every frame and every inter-frame gap takes only a few cycles, so the bench can measure them cycle by cycle against the expected minimum gap of four system clocks.

// File: rtl/spi_chan_pkg.sv
package spi_chan_pkg;
  localparam logic [7:0] CMD_READ  = 8'h60;
  localparam logic [7:0] CMD_WRITE = 8'h20;
  localparam logic [7:0] CMD_ALL   = 8'h80;
  localparam logic [7:0] CHAN_ALL  = 8'hFF;
  localparam int         CHAN_BITS = 5;
  localparam int         FRAMES    = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/spi_chan_cmd_enc.sv
module spi_chan_cmd_enc
  import spi_chan_pkg::*;
#(
  parameter int CHAN_MAX = 16
) (
  input  logic [7:0] chan,
  input  logic       write,
  input  logic       bcast,
  output logic [7:0] cmd,
  output logic       bad
);
  logic [CHAN_BITS-1:0] rev;
  logic                 all_sel;

  for (genvar i = 0; i < CHAN_BITS; i++) begin : g_rev
    assign rev[CHAN_BITS-1-i] = chan[i];
  end

  assign all_sel = bcast || (chan == CHAN_ALL);

  always_comb begin
    bad = 1'b0;
    cmd = 8'h00;
    if (all_sel) begin
      cmd = CMD_ALL | CMD_WRITE;
      bad = !write;
    end else begin
      cmd = (write ? CMD_WRITE : CMD_READ) | {3'b000, rev};
      bad = ({24'd0, chan} >= CHAN_MAX);
    end
  end
endmodule

// File: rtl/spi_chan_byte_shift.sv
module spi_chan_byte_shift #(
  parameter int HALF_DIV  = 2,
  parameter int GAP_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       cs_n,
  output logic       mosi,
  input  logic       miso
);
  localparam int END_PH = 16 + GAP_TICKS;
  localparam int PH_W   = $clog2(END_PH + 1);
  localparam int DIV_W  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic             active_q, active_d;
  logic [PH_W-1:0]  ph_q, ph_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [7:0]       tx_q, tx_d, rx_q, rx_d;
  logic             sclk_q, sclk_d, cs_q, cs_d, mosi_q, mosi_d, done_q, done_d;
  logic             tick;

  assign tick = active_q && (div_q == DIV_W'(HALF_DIV - 1));

  always_comb begin
    active_d = active_q;
    ph_d     = ph_q;
    div_d    = div_q;
    tx_d     = tx_q;
    rx_d     = rx_q;
    sclk_d   = sclk_q;
    cs_d     = cs_q;
    mosi_d   = mosi_q;
    done_d   = 1'b0;
    if (start && !active_q) begin
      active_d = 1'b1;
      ph_d     = '0;
      div_d    = '0;
      tx_d     = tx_byte;
      cs_d     = 1'b0;
    end else if (active_q) begin
      if (tick) begin
        div_d = '0;
        ph_d  = ph_q + 1'b1;
        if (ph_q < PH_W'(16)) begin
          if (!ph_q[0]) begin
            sclk_d = 1'b0;
            mosi_d = tx_q[7];
            tx_d   = {tx_q[6:0], 1'b0};
          end else begin
            sclk_d = 1'b1;
            rx_d   = {rx_q[6:0], miso};
          end
        end else if (ph_q == PH_W'(16)) begin
          cs_d = 1'b1;
        end
        if (ph_q == PH_W'(END_PH)) begin
          active_d = 1'b0;
          done_d   = 1'b1;
        end
      end else begin
        div_d = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      ph_q     <= '0;
      div_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      sclk_q   <= 1'b1;
      cs_q     <= 1'b1;
      mosi_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      ph_q     <= ph_d;
      div_q    <= div_d;
      tx_q     <= tx_d;
      rx_q     <= rx_d;
      sclk_q   <= sclk_d;
      cs_q     <= cs_d;
      mosi_q   <= mosi_d;
      done_q   <= done_d;
    end
  end

  assign byte_done = done_q;
  assign rx_byte   = rx_q;
  assign sclk      = sclk_q;
  assign cs_n      = cs_q;
  assign mosi      = mosi_q;

  // R7
  idle_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> sclk_q);

  // R7
  mosi_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi_q) |-> $fell(sclk_q));

  // R8
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_q) |=> cs_q);
endmodule

// File: rtl/spi_chan_master.sv
module spi_chan_master
  import spi_chan_pkg::*;
#(
  parameter int CHAN_MAX  = 16,
  parameter int HALF_DIV  = 2,
  parameter int GAP_TICKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [7:0] req_chan,
  input  logic [7:0] req_addr,
  input  logic       req_write,
  input  logic       req_bcast,
  input  logic [7:0] req_wdata,
  output logic       done,
  output logic       err,
  output logic [7:0] rd_data,
  output logic       sclk,
  output logic       cs_n,
  output logic       mosi,
  input  logic       miso
);
  localparam int IDX_W = $clog2(FRAMES);

  seq_state_e       st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [7:0]       cmd_q, cmd_d, addr_q, addr_d, wd_q, wd_d, rd_q, rd_d;
  logic             rd_op_q, rd_op_d, err_q, err_d, start_q, start_d;
  logic [7:0]       enc_cmd, tx_sel, rx_byte;
  logic             enc_bad, byte_done, accept;

  spi_chan_cmd_enc #(.CHAN_MAX(CHAN_MAX)) enc_i (
    .chan  (req_chan),
    .write (req_write),
    .bcast (req_bcast),
    .cmd   (enc_cmd),
    .bad   (enc_bad)
  );

  always_comb begin
    case (idx_q)
      IDX_W'(0): tx_sel = cmd_q;
      IDX_W'(1): tx_sel = addr_q;
      default:   tx_sel = rd_op_q ? 8'h00 : wd_q;
    endcase
  end

  spi_chan_byte_shift #(.HALF_DIV(HALF_DIV), .GAP_TICKS(GAP_TICKS)) shf_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_q),
    .tx_byte   (tx_sel),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .miso      (miso)
  );

  assign accept = req_valid && (st_q == ST_IDLE);

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    cmd_d   = cmd_q;
    addr_d  = addr_q;
    wd_d    = wd_q;
    rd_d    = rd_q;
    rd_op_d = rd_op_q;
    err_d   = err_q;
    start_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          cmd_d   = enc_cmd;
          addr_d  = req_addr;
          wd_d    = req_wdata;
          rd_op_d = !req_write;
          err_d   = enc_bad;
          idx_d   = '0;
          if (enc_bad) begin
            st_d = ST_DONE;
          end else begin
            st_d    = ST_RUN;
            start_d = 1'b1;
          end
        end
      end
      ST_RUN: begin
        if (byte_done) begin
          if (idx_q == IDX_W'(FRAMES - 1)) begin
            st_d = ST_DONE;
            if (rd_op_q) rd_d = rx_byte;
          end else begin
            idx_d   = idx_q + 1'b1;
            start_d = 1'b1;
          end
        end
      end
      default: begin
        st_d  = ST_IDLE;
        err_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      cmd_q   <= '0;
      addr_q  <= '0;
      wd_q    <= '0;
      rd_q    <= '0;
      rd_op_q <= 1'b0;
      err_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      start_q <= start_d;
      err_q   <= err_d;
      rd_op_q <= rd_op_d;
      if (accept) begin
        cmd_q  <= cmd_d;
        addr_q <= addr_d;
        wd_q   <= wd_d;
      end
      if (st_q == ST_RUN) rd_q <= rd_d;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign done      = (st_q == ST_DONE);
  assign err       = (st_q == ST_DONE) && err_q;
  assign rd_data   = rd_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R9
  idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cs_n);

  // R4
  reject_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && enc_bad) |=> (cs_n && err));
endmodule

// File: tb/spi_chan_master_tb_top.sv
module spi_chan_master_tb_top;
  localparam int CHAN_MAX = 8;
  localparam int HALF_DIV = 2;
  localparam int GAP_T    = 2;

  logic       clk, rst_n, req_valid, req_ready, req_write, req_bcast;
  logic [7:0] req_chan, req_addr, req_wdata, rd_data;
  logic       done, err, sclk, cs_n, mosi, miso;

  int n_chk, n_err;

  spi_chan_master #(.CHAN_MAX(CHAN_MAX), .HALF_DIV(HALF_DIV), .GAP_TICKS(GAP_T)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .req_addr(req_addr), .req_write(req_write),
    .req_bcast(req_bcast), .req_wdata(req_wdata), .done(done), .err(err),
    .rd_data(rd_data), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // channel model
  logic [7:0] frm [0:7];
  int         frm_bits [0:7];
  int         nfrm, bitc, fallc, gap_run, min_gap, act_cyc;
  logic [7:0] shreg, ret_byte;

  always @(negedge cs_n) begin
    bitc  = 0;
    fallc = 0;
    shreg = 8'h00;
  end
  always @(negedge sclk) if (!cs_n) begin
    miso  = ret_byte[7 - (fallc % 8)];
    fallc = fallc + 1;
  end
  always @(posedge sclk) if (!cs_n) begin
    shreg = {shreg[6:0], mosi};
    bitc  = bitc + 1;
  end
  always @(posedge cs_n) if (nfrm < 8) begin
    frm[nfrm]      = shreg;
    frm_bits[nfrm] = bitc;
    nfrm           = nfrm + 1;
  end
  always @(posedge clk) begin
    if (!cs_n) act_cyc = act_cyc + 1;
    if (cs_n && nfrm > 0) gap_run = gap_run + 1;
    if (!cs_n && gap_run > 0) begin
      if (gap_run < min_gap) min_gap = gap_run;
      gap_run = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rev5(input int ch);
    int r = 0;
    for (int i = 0; i < 5; i++) if (((ch >> i) & 1) != 0) r += (1 << (4 - i));
    return 8'(r);
  endfunction

  task automatic run_op(input int ch, input logic [7:0] ad, input bit wr, input bit bc,
                        input logic [7:0] wd, input logic [7:0] rb, input bit expect_err);
    logic [7:0] exp_cmd;
    bit         got;
    bit         all_sel = bc || (ch == 255);
    int         wait_n;
    logic [7:0] prev_rd = rd_data;
    nfrm = 0; gap_run = 0; min_gap = 1000; act_cyc = 0; ret_byte = rb;
    @(negedge clk);
    req_valid = 1'b1; req_chan = 8'(ch); req_addr = ad; req_write = wr;
    req_bcast = bc; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (expect_err) begin
      chk(done === 1'b1 && err === 1'b1, "R4 err/done next cycle", {err, done}, 3);
      @(negedge clk);
      chk(act_cyc == 0 && nfrm == 0, "R4 no bus activity", nfrm, 0);
      chk(rd_data === prev_rd, "R9 rd_data held", rd_data, prev_rd);
      return;
    end
    chk(req_ready === 1'b0, "R9 ready low while busy", req_ready, 0);
    got = 0;
    wait_n = 0;
    while (!got && wait_n < 2000) begin
      if (done === 1'b1) got = 1;
      else begin @(negedge clk); wait_n++; end
    end
    chk(got, "R9 done seen", got, 1);
    chk(err === 1'b0, "R4 no error on legal request", err, 0);
    @(negedge clk);
    chk(done === 1'b0 && req_ready === 1'b1, "R9 done single pulse", done, 0);
    exp_cmd = all_sel ? 8'hA0 : ((wr ? 8'h20 : 8'h60) | rev5(ch));
    chk(nfrm == 3, wr ? "R5 three frames" : "R6 three frames", nfrm, 3);
    chk(frm[0] == exp_cmd, all_sel ? "R3 broadcast cmd" : (wr ? "R1 R2 write cmd" : "R1 R2 read cmd"),
        frm[0], exp_cmd);
    chk(frm[1] == ad, "R5 address frame", frm[1], ad);
    if (wr) chk(frm[2] == wd, "R5 data frame", frm[2], wd);
    else    chk(rd_data == rb, "R6 read data", rd_data, rb);
    for (int k = 0; k < 3; k++)
      chk(frm_bits[k] == 8, "R8 eight rising edges", frm_bits[k], 8);
    chk(min_gap >= 2 * HALF_DIV, "R8 inter-frame gap", min_gap, 2 * HALF_DIV);
  endtask

  initial begin
    n_chk = 0; n_err = 0; nfrm = 0; gap_run = 0; min_gap = 1000; act_cyc = 0;
    miso = 1'b0; ret_byte = 8'h00; bitc = 0; fallc = 0; shreg = 8'h00;
    req_valid = 1'b0; req_chan = 8'h00; req_addr = 8'h00; req_write = 1'b0;
    req_bcast = 1'b0; req_wdata = 8'h00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b1 && req_ready === 1'b1 && done === 1'b0 && err === 1'b0,
        "R10 reset state", {cs_n, sclk, req_ready, done, err}, 5'b11100);
    // R1 R2 R5 R6: every legal channel in both directions
    for (int c = 0; c < CHAN_MAX; c++) begin
      run_op(c, 8'(c * 17 + 3), 1'b1, 1'b0, 8'(8'hA5 ^ c), 8'h00, 1'b0);
      run_op(c, 8'(c * 5 + 40), 1'b0, 1'b0, 8'h00, 8'(8'h3C + c * 29), 1'b0);
    end
    // R3 broadcast writes
    run_op(255, 8'h12, 1'b1, 1'b0, 8'h5A, 8'h00, 1'b0);
    run_op(3,   8'h22, 1'b1, 1'b1, 8'hC3, 8'h00, 1'b0);
    // R4 refused requests
    run_op(CHAN_MAX, 8'h01, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1);
    run_op(31,       8'h01, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1);
    run_op(254,      8'h01, 1'b1, 1'b0, 8'h00, 8'h00, 1'b1);
    run_op(255,      8'h01, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1);
    run_op(2,        8'h01, 1'b0, 1'b1, 8'h00, 8'h00, 1'b1);
    // R6 extremes of returned data
    run_op(1, 8'hFF, 1'b0, 1'b0, 8'h00, 8'hFF, 1'b0);
    run_op(1, 8'h00, 1'b0, 1'b0, 8'h00, 8'h01, 1'b0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule